// File: doc/BRIEF.md
# SDRAM Access Sequencer with Auto-Precharge

This block sits between a simple host port and a single SDRAM device with a 16-bit data bus. Each host request is one 16-bit read or write. The block turns it into a fixed command train: a row open, a column access that closes the row by itself, and a fixed recovery gap. No row is ever left open between accesses, so every access costs the same number of cycles whatever address came before it.

Refresh is requested from outside through a single pulse input. The block remembers the pulse and issues an auto-refresh command at the next point between transactions, ahead of any host access waiting at that point. Each refresh is followed by a fixed idle gap. The device's mode register is assumed to be already loaded with CAS latency 3; power-up initialisation is not part of this block.

The host address is laid out as {bank[1:0], row[12:0], column[9:0]}. All command pins are registered. A command is held for exactly one clock.

Top module: `sdram_seq`

## Requirements
- R1: While `rst` is high, the command pins show deselect ({cs_n,ras_n,cas_n,we_n} = 1111), `mem_dqm` is 11, `host_ready` is 1 and `host_rvalid` is 0. In the first cycle after reset is released, the command is NOP (0111).
- R2: A request is accepted at a clock edge where both `host_req` and `host_ready` are high, and no refresh is due. In the next cycle the block issues ACTIVE (0011), with `mem_ba` = address bits [24:23] and `mem_addr` = address bits [22:10].
- R3: The column command comes exactly 3 cycles after ACTIVE, with NOP in the two cycles between. It is READ (0101) or WRITE (0100) according to `host_we`. It carries the same bank, and `mem_addr` = column bits [9:0] with bit 10 set for auto-precharge and bits 12:11 clear.
- R4: For a read, the value on `mem_dq` in the cycle 3 clocks after READ appears on `host_rdata`, with `host_rvalid` high for exactly one cycle, which is the cycle 4 clocks after READ.
- R5: In the WRITE cycle, the block drives `mem_dq` with the write data that was accepted with the request.
- R6: With no refresh due, `host_ready` returns high 4 cycles after WRITE (2 recovery cycles plus 1 precharge cycle) and 5 cycles after READ. It is low in every cycle between acceptance and that point.
- R7: A refresh pulse seen while idle produces a REFRESH command (0001) in the next cycle. REFRESH is followed by exactly 8 NOP cycles, and `host_ready` is high again 9 cycles after REFRESH.
- R8: A refresh pulse that arrives during a transaction is remembered. REFRESH is issued in the cycle right after that transaction's precharge cycle, and `host_ready` stays low until 9 cycles after that REFRESH.
- R9: When a refresh pulse and an accepted host request meet at the same edge, REFRESH goes first. The host's ACTIVE follows exactly 9 cycles after REFRESH, and the access then completes normally.
- R10: `host_ready` is low in every cycle that carries ACTIVE, READ, WRITE or REFRESH. A `host_req` pulse given while `host_ready` is low produces no command.
- R11: `mem_dqm` is 00 in the WRITE cycle and in the cycles from READ up to 3 cycles after READ. It is 11 in every other cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 25 | {bank, row, column} |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | One-cycle pulse with read data |
| host_ready | output | 1 | Block can accept a request |
| refresh_req | input | 1 | Refresh request pulse |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank select |
| mem_addr | output | 13 | Multiplexed row/column address |
| mem_dqm | output | 2 | Byte masks |
| mem_dq | inout | 16 | Data bus |

## Verification
Reads and writes are swept over walking-one and walking-zero addresses across all 25 address bits. This separates every bank, row and column bit in both the ACTIVE and column phases and exposes any swapped or dropped bit. For reads, the bench puts a decoy value on the bus in the cycles before and after the true data cycle, so a capture that is one cycle early or late is caught. Refresh is tried in three ways: alone while idle, arriving during a read or a write, and meeting a host request at the same edge. Each tells apart the idle gap, the remembered request and the ordering rule. Request pulses given while busy confirm that no command follows them.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RD,
    ST_WR,
    ST_PRE,
    ST_REF
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdram_cmd_t;

  localparam sdram_cmd_t CMD_DESEL = 4'b1111;
  localparam sdram_cmd_t CMD_NOP   = 4'b0111;
  localparam sdram_cmd_t CMD_ACT   = 4'b0011;
  localparam sdram_cmd_t CMD_READ  = 4'b0101;
  localparam sdram_cmd_t CMD_WRITE = 4'b0100;
  localparam sdram_cmd_t CMD_REF   = 4'b0001;

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_seq_addrmap.sv
module sdram_seq_addrmap #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [ROW_W-1:0]  colcmd
);

  assign bank = addr[ADDR_W-1 -: BANK_W];
  assign row  = addr[COL_W +: ROW_W];

  always_comb begin
    colcmd              = '0;
    colcmd[COL_W-1:0]   = addr[COL_W-1:0];
    colcmd[AP_BIT]      = 1'b1;
  end

endmodule

// File: rtl/sdram_seq_rdcap.sv
module sdram_seq_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int BANK_W  = 2,
  parameter int AP_BIT  = 10,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 3,
  parameter int T_WR    = 2,
  parameter int T_RP    = 1,
  parameter int T_RFC   = 8,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int DQM_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              host_ready,
  input  logic              refresh_req,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BANK_W-1:0] mem_ba,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [DQM_W-1:0]  mem_dqm,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int GAP_A   = (T_RCD > CAS_LAT + 1) ? T_RCD : CAS_LAT + 1;
  localparam int GAP_B   = (T_WR + 1 > T_RP) ? T_WR + 1 : T_RP;
  localparam int GAP_C   = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int MAX_GAP = (GAP_C > T_RFC + 1) ? GAP_C : T_RFC + 1;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_CL  = CNT_W'(CAS_LAT);
  localparam logic [CNT_W-1:0] LD_WR  = CNT_W'(T_WR);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC);

  seq_state_e        state_q, state_d;
  sdram_cmd_t        cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ROW_W-1:0]  ma_q, ma_d;
  logic [DQM_W-1:0]  dqm_q, dqm_d;
  logic              dq_oe_q, dq_oe_d;
  logic [DATA_W-1:0] dq_out_q;
  logic              ready_q;
  logic              acc_pend_q, acc_pend_d;
  logic              ref_pend_q, ref_pend_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic              take;
  logic              ref_want;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic              capture;
  logic [ADDR_W-1:0] map_in;
  logic [BANK_W-1:0] map_bank;
  logic [ROW_W-1:0]  map_row;
  logic [ROW_W-1:0]  map_col;

  assign take     = host_req && ready_q;
  assign ref_want = ref_pend_q || refresh_req;
  assign map_in   = (state_q == ST_IDLE) ? host_addr : addr_q;

  sdram_seq_addrmap #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W),
    .AP_BIT (AP_BIT)
  ) u_addrmap (
    .addr   (map_in),
    .bank   (map_bank),
    .row    (map_row),
    .colcmd (map_col)
  );

  sdram_seq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sdram_seq_rdcap #(
    .DATA_W (DATA_W)
  ) u_rdcap (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .dq_in   (mem_dq),
    .rdata   (host_rdata),
    .rvalid  (host_rvalid)
  );

  always_comb begin
    state_d    = state_q;
    cmd_d      = CMD_NOP;
    ba_d       = ba_q;
    ma_d       = ma_q;
    dqm_d      = '1;
    dq_oe_d    = 1'b0;
    acc_pend_d = acc_pend_q;
    ref_pend_d = ref_pend_q || refresh_req;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    capture    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (ref_want) begin
          state_d    = ST_REF;
          cmd_d      = CMD_REF;
          ref_pend_d = 1'b0;
          tmr_load   = 1'b1;
          tmr_val    = LD_RFC;
          if (take) acc_pend_d = 1'b1;
        end else if (take) begin
          state_d  = ST_ACT;
          cmd_d    = CMD_ACT;
          ba_d     = map_bank;
          ma_d     = map_row;
          tmr_load = 1'b1;
          tmr_val  = LD_RCD;
        end
      end
      ST_ACT: begin
        if (tmr_zero) begin
          ba_d     = map_bank;
          ma_d     = map_col;
          dqm_d    = '0;
          tmr_load = 1'b1;
          if (we_q) begin
            state_d = ST_WR;
            cmd_d   = CMD_WRITE;
            dq_oe_d = 1'b1;
            tmr_val = LD_WR;
          end else begin
            state_d = ST_RD;
            cmd_d   = CMD_READ;
            tmr_val = LD_CL;
          end
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          capture  = 1'b1;
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
        end else begin
          dqm_d = '0;
        end
      end
      ST_WR: begin
        if (tmr_zero) begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
        end
      end
      ST_PRE: begin
        if (tmr_zero) begin
          if (ref_want) begin
            state_d    = ST_REF;
            cmd_d      = CMD_REF;
            ref_pend_d = 1'b0;
            tmr_load   = 1'b1;
            tmr_val    = LD_RFC;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_REF: begin
        if (tmr_zero) begin
          if (acc_pend_q) begin
            state_d    = ST_ACT;
            cmd_d      = CMD_ACT;
            ba_d       = map_bank;
            ma_d       = map_row;
            acc_pend_d = 1'b0;
            tmr_load   = 1'b1;
            tmr_val    = LD_RCD;
          end else if (ref_want) begin
            state_d    = ST_REF;
            cmd_d      = CMD_REF;
            ref_pend_d = 1'b0;
            tmr_load   = 1'b1;
            tmr_val    = LD_RFC;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cmd_q      <= CMD_DESEL;
      ba_q       <= '0;
      ma_q       <= '0;
      dqm_q      <= '1;
      dq_oe_q    <= 1'b0;
      dq_out_q   <= '0;
      ready_q    <= 1'b1;
      acc_pend_q <= 1'b0;
      ref_pend_q <= 1'b0;
      we_q       <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else begin
      state_q    <= state_d;
      cmd_q      <= cmd_d;
      ba_q       <= ba_d;
      ma_q       <= ma_d;
      dqm_q      <= dqm_d;
      dq_oe_q    <= dq_oe_d;
      dq_out_q   <= wdata_q;
      ready_q    <= (state_d == ST_IDLE);
      acc_pend_q <= acc_pend_d;
      ref_pend_q <= ref_pend_d;
      if (take) begin
        we_q    <= host_we;
        addr_q  <= host_addr;
        wdata_q <= host_wdata;
      end
    end
  end

  assign host_ready = ready_q;
  assign mem_cs_n   = cmd_q.cs_n;
  assign mem_ras_n  = cmd_q.ras_n;
  assign mem_cas_n  = cmd_q.cas_n;
  assign mem_we_n   = cmd_q.we_n;
  assign mem_ba     = ba_q;
  assign mem_addr   = ma_q;
  assign mem_dqm    = dqm_q;
  assign mem_dq     = dq_oe_q ? dq_out_q : 'z;

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int DATA_W  = 16,
  parameter int ROW_W   = 13,
  parameter int BANK_W  = 2,
  parameter int AP_BIT  = 10,
  parameter int T_RCD   = 3,
  parameter int CAS_LAT = 3,
  parameter int T_RFC   = 8,
  localparam int DQM_W  = DATA_W / 8
) (
  input logic             clk,
  input logic             rst,
  input logic             host_ready,
  input logic             host_rvalid,
  input logic             mem_cs_n,
  input logic             mem_ras_n,
  input logic             mem_cas_n,
  input logic             mem_we_n,
  input logic [ROW_W-1:0] mem_addr,
  input logic [DQM_W-1:0] mem_dqm
);

  localparam int GAP_W = $clog2(T_RFC + 2) + 1;

  logic is_act, is_rd, is_wr, is_ref;
  logic [GAP_W-1:0] since_ref;
  logic             ref_seen;

  assign is_act = !mem_cs_n && !mem_ras_n &&  mem_cas_n &&  mem_we_n;
  assign is_rd  = !mem_cs_n &&  mem_ras_n && !mem_cas_n &&  mem_we_n;
  assign is_wr  = !mem_cs_n &&  mem_ras_n && !mem_cas_n && !mem_we_n;
  assign is_ref = !mem_cs_n && !mem_ras_n && !mem_cas_n &&  mem_we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_ref <= '0;
      ref_seen  <= 1'b0;
    end else if (is_ref) begin
      since_ref <= '0;
      ref_seen  <= 1'b1;
    end else if (since_ref != '1) begin
      since_ref <= since_ref + 1'b1;
    end
  end

  assert_col_after_act_R3: assert property (@(posedge clk) disable iff (rst)
    (is_rd || is_wr) |-> $past(is_act, T_RCD));

  assert_autoprecharge_R3: assert property (@(posedge clk) disable iff (rst)
    (is_rd || is_wr) |-> mem_addr[AP_BIT]);

  assert_rvalid_timing_R4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(is_rd, CAS_LAT + 1));

  assert_rvalid_single_R4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  assert_busy_on_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    (is_act || is_rd || is_wr || is_ref) |-> !host_ready);

  assert_write_mask_R11: assert property (@(posedge clk) disable iff (rst)
    is_wr |-> (mem_dqm == '0));

  assert_refresh_gap_R7: assert property (@(posedge clk) disable iff (rst)
    ((is_act || is_ref) && ref_seen) |-> (since_ref >= GAP_W'(T_RFC)));

endmodule

bind sdram_seq sdram_seq_chk #(
  .DATA_W  (DATA_W),
  .ROW_W   (ROW_W),
  .BANK_W  (BANK_W),
  .AP_BIT  (AP_BIT),
  .T_RCD   (T_RCD),
  .CAS_LAT (CAS_LAT),
  .T_RFC   (T_RFC)
) u_sdram_seq_chk (
  .clk         (clk),
  .rst         (rst),
  .host_ready  (host_ready),
  .host_rvalid (host_rvalid),
  .mem_cs_n    (mem_cs_n),
  .mem_ras_n   (mem_ras_n),
  .mem_cas_n   (mem_cas_n),
  .mem_we_n    (mem_we_n),
  .mem_addr    (mem_addr),
  .mem_dqm     (mem_dqm)
);

// File: tb/test_sdram_seq.sv
module test_sdram_seq;

  localparam int CLK_PERIOD = 10;
  localparam int T_RFC      = 8;
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_REF = 4'b0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [24:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rvalid;
  logic        host_ready;
  logic        refresh_req = 1'b0;
  logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [1:0]  mem_ba;
  logic [12:0] mem_addr;
  logic [1:0]  mem_dqm;
  wire  [15:0] mem_dq;
  logic [15:0] tb_dq = '0;
  logic        tb_dq_en = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  assign mem_dq = tb_dq_en ? tb_dq : 16'bz;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_seq i_sdram_seq (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .host_ready  (host_ready),
    .refresh_req (refresh_req),
    .mem_cs_n    (mem_cs_n),
    .mem_ras_n   (mem_ras_n),
    .mem_cas_n   (mem_cas_n),
    .mem_we_n    (mem_we_n),
    .mem_ba      (mem_ba),
    .mem_addr    (mem_addr),
    .mem_dqm     (mem_dqm),
    .mem_dq      (mem_dq)
  );

  function automatic logic [3:0] cmd();
    return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  endfunction

  function automatic logic [15:0] pattern(input logic [24:0] a);
    return a[15:0] ^ {a[24:16], 7'h35} ^ 16'hA5C3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Called at the negedge of the ACTIVE cycle; returns at the negedge where ready is high.
  task automatic follow(input bit we, input logic [24:0] a, input logic [15:0] d,
                        input bit poke_req, input bit poke_ref);
    int mid;
    chk("R2 act cmd", 32'(cmd()), 32'(C_ACT));
    chk("R2 act bank", 32'(mem_ba), 32'(a[24:23]));
    chk("R2 act row", 32'(mem_addr), 32'(a[22:10]));
    chk("R10 busy at act", 32'(host_ready), 32'd0);
    repeat (2) begin
      tick();
      chk("R3 nop before column", 32'(cmd()), 32'(C_NOP));
    end
    tick();
    chk("R3 column cmd", 32'(cmd()), 32'(we ? C_WR : C_RD));
    chk("R3 column addr", 32'(mem_addr), 32'(13'h0400 | {3'b000, a[9:0]}));
    chk("R3 column bank", 32'(mem_ba), 32'(a[24:23]));
    chk("R11 mask at column", 32'(mem_dqm), 32'd0);
    if (we) chk("R5 write data", 32'(mem_dq), 32'(d));
    mid = we ? 3 : 4;
    for (int k = 1; k <= mid; k++) begin
      tick();
      if (k == 1) begin
        if (poke_req) host_req = 1'b1;
        if (poke_ref) refresh_req = 1'b1;
      end
      if (k == 2) begin
        host_req = 1'b0;
        refresh_req = 1'b0;
      end
      if (!we) begin
        if (k == 2) begin tb_dq = ~d; tb_dq_en = 1'b1; end
        if (k == 3) tb_dq = d;
        if (k == 4) tb_dq = ~d;
        chk("R11 read mask", 32'(mem_dqm), (k <= 3) ? 32'd0 : 32'd3);
        chk("R4 rvalid", 32'(host_rvalid), (k == 4) ? 32'd1 : 32'd0);
        if (k == 4) chk("R4 read data", 32'(host_rdata), 32'(d));
      end else begin
        chk("R11 mask after write", 32'(mem_dqm), 32'd3);
      end
      chk("R6 busy", 32'(host_ready), 32'd0);
      chk("R10 nop while busy", 32'(cmd()), 32'(C_NOP));
    end
    tick();
    tb_dq_en = 1'b0;
    if (!we) chk("R4 rvalid single", 32'(host_rvalid), 32'd0);
    if (poke_ref) begin
      chk("R8 deferred refresh", 32'(cmd()), 32'(C_REF));
      chk("R8 busy at refresh", 32'(host_ready), 32'd0);
      repeat (T_RFC) begin
        tick();
        chk("R7 nop after refresh", 32'(cmd()), 32'(C_NOP));
        chk("R8 busy during refresh", 32'(host_ready), 32'd0);
      end
      tick();
      chk("R8 ready after refresh", 32'(host_ready), 32'd1);
    end else begin
      chk("R6 ready returns", 32'(host_ready), 32'd1);
      chk("R6 idle nop", 32'(cmd()), 32'(C_NOP));
    end
    if (poke_req) begin
      repeat (3) begin
        tick();
        chk("R10 ignored request", 32'(cmd()), 32'(C_NOP));
        chk("R10 still ready", 32'(host_ready), 32'd1);
      end
    end
  endtask

  task automatic access(input bit we, input logic [24:0] a, input logic [15:0] d,
                        input bit poke_req, input bit poke_ref);
    host_req = 1'b1;
    host_we = we;
    host_addr = a;
    host_wdata = d;
    tick();
    host_req = 1'b0;
    follow(we, a, d, poke_req, poke_ref);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [24:0] a;
    repeat (3) tick();
    chk("R1 reset cmd", 32'(cmd()), 32'(C_DES));
    chk("R1 reset mask", 32'(mem_dqm), 32'd3);
    chk("R1 reset ready", 32'(host_ready), 32'd1);
    chk("R1 reset rvalid", 32'(host_rvalid), 32'd0);
    rst = 1'b0;
    tick();
    chk("R1 nop after reset", 32'(cmd()), 32'(C_NOP));
    chk("R1 ready after reset", 32'(host_ready), 32'd1);

    // Address sweep: walking one and walking zero, write then read
    for (int i = 0; i < 25; i++) begin
      a = 25'(1) << i;
      access(1'b1, a, pattern(a), 1'b0, 1'b0);
      access(1'b0, a, ~pattern(a), 1'b0, 1'b0);
      a = ~(25'(1) << i);
      access(1'b1, a, ~pattern(a), 1'b0, 1'b0);
      access(1'b0, a, pattern(a), 1'b0, 1'b0);
    end

    // R10: request pulses while busy
    access(1'b1, 25'h0ABCDEF, 16'h1234, 1'b1, 1'b0);
    access(1'b0, 25'h1234567, 16'hBEEF, 1'b1, 1'b0);

    // R7: refresh while idle
    refresh_req = 1'b1;
    tick();
    refresh_req = 1'b0;
    chk("R7 refresh cmd", 32'(cmd()), 32'(C_REF));
    chk("R7 busy at refresh", 32'(host_ready), 32'd0);
    repeat (T_RFC) begin
      tick();
      chk("R7 refresh gap nop", 32'(cmd()), 32'(C_NOP));
      chk("R7 refresh gap busy", 32'(host_ready), 32'd0);
    end
    tick();
    chk("R7 ready after gap", 32'(host_ready), 32'd1);
    chk("R7 nop after gap", 32'(cmd()), 32'(C_NOP));

    // R8: refresh arriving during a read and during a write
    access(1'b0, 25'h0F0F0F0, 16'h5A5A, 1'b0, 1'b1);
    access(1'b1, 25'h1555555, 16'hC3C3, 1'b0, 1'b1);

    // R9: refresh and request at the same edge
    a = 25'h1AAAAAA;
    host_req = 1'b1;
    host_we = 1'b0;
    host_addr = a;
    refresh_req = 1'b1;
    tick();
    host_req = 1'b0;
    refresh_req = 1'b0;
    chk("R9 refresh first", 32'(cmd()), 32'(C_REF));
    chk("R9 busy", 32'(host_ready), 32'd0);
    repeat (T_RFC) begin
      tick();
      chk("R9 nop gap", 32'(cmd()), 32'(C_NOP));
    end
    tick();
    chk("R9 active after refresh", 32'(cmd()), 32'(C_ACT));
    follow(1'b0, a, 16'h7E81, 1'b0, 1'b0);

    a = 25'h0333333;
    host_req = 1'b1;
    host_we = 1'b1;
    host_addr = a;
    host_wdata = 16'h9009;
    refresh_req = 1'b1;
    tick();
    host_req = 1'b0;
    refresh_req = 1'b0;
    chk("R9 refresh first write", 32'(cmd()), 32'(C_REF));
    repeat (T_RFC) tick();
    tick();
    chk("R9 active after refresh write", 32'(cmd()), 32'(C_ACT));
    follow(1'b1, a, 16'h9009, 1'b0, 1'b0);

    repeat (4) tick();
    summary();
  end

endmodule